// File: doc/BRIEF.md
# Page Write Buffer and Commit Sequencer

This block sits between the serial bus controller of a small nonvolatile memory and its storage array. It collects the data bytes of one write transaction into a page buffer. When the transaction ends with a Stop, it commits the page to the array in a single self-timed write cycle. The bus controller opens a transaction by presenting the target address with `wr_open`. It then passes each received data byte with `data_vld`. It ends the transaction with either `bus_stop` or `bus_abort`. `bus_abort` covers a repeated Start and an interface timeout.

Bytes are placed by the low address bits, which advance and wrap inside the page. The page bits stay fixed for the whole transaction. If more bytes arrive than the page holds, the oldest are overwritten in arrival order, so only the last page-full remains. Four write-protect flags cover four equal blocks of the address space. A commit aimed at a protected block is dropped quietly. During a write cycle, `busy` stays high for a fixed number of clock cycles. The bus controller uses it to withhold acknowledges, and the block ignores all of its transaction inputs during that time.

Top module: `pwb_page_writer`

## Requirements
- R1: After reset, `busy` and `mem_we` are low.
- R2: A data byte is held for array address {page of `wr_addr`, slot}. The first byte's slot is `wr_addr[3:0]`. Each following byte uses the next slot, and slot 15 wraps to slot 0. Address bits [8:4] never change within a transaction.
- R3: When more than 16 bytes arrive, each slot keeps the latest byte written to it. The commit therefore holds exactly the last 16 bytes.
- R4: `bus_abort` before the Stop discards the buffered bytes. No array write follows, and `busy` stays low.
- R5: Address bits [8:7] select a protection block, and `wp_block[i]` protects block i. A Stop in a protected block causes no array write, and `busy` stays low.
- R6: On a Stop with at least one buffered byte in an unprotected block, `busy` rises in the cycle after the Stop is sampled. It stays high for exactly WRITE_CYCLES cycles.
- R7: During the write cycle, each buffered slot is written to the array exactly once. No address is written that was not buffered. `mem_we` is high only while `busy` is high.
- R8: While `busy` is high, `wr_open`, `data_vld` and `bus_stop` are ignored. No second write cycle and no extra array write result.
- R9: A Stop with no buffered byte starts no write cycle. This covers no bytes sent and bytes sent outside an open transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_open | input | 1 | Opens a write transaction at `wr_addr` |
| wr_addr | input | 9 | Starting array address |
| data_vld | input | 1 | One received data byte is valid |
| data_byte | input | 8 | Received data byte |
| bus_stop | input | 1 | Stop seen on the bus |
| bus_abort | input | 1 | Start or timeout before Stop |
| wp_block | input | 4 | Write-protect flag per 128-byte block |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | 9 | Array write address |
| mem_wdata | output | 8 | Array write data |
| busy | output | 1 | Write cycle in progress |

## Verification
The in-RTL assertions cover the rules that can be judged from a single cycle or a few cycles. On every cycle they check that array writes occur only while busy and that busy only rises after a Stop. They also check that no cycle starts for a protected block, that an abort empties the buffer, that every accepted byte marks its slot, and that the page is frozen while busy. The random and directed transactions of the bench are needed for the rest. Only they can show that the committed page holds the correct last bytes after a wrap or an overflow, and that busy lasts exactly the programmed length. They also show that a disturbance during the write cycle leaves no trace.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
   typedef enum logic [1:0] {
      PWB_IDLE   = 2'd0,
      PWB_FILL   = 2'd1,
      PWB_COMMIT = 2'd2
   } pwb_state_e;
endpackage

// File: rtl/pwb_page_store.sv
module pwb_page_store #(
   parameter  int DATA_W     = 8,
   parameter  int PAGE_BYTES = 16,
   localparam int OFS_W      = $clog2(PAGE_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [OFS_W-1:0]  load_ofs,
   input  logic              clear,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic [OFS_W-1:0]  rd_idx,
   output logic              rd_vld,
   output logic [DATA_W-1:0] rd_data,
   output logic              any_vld
);
   if ((1 << OFS_W) != PAGE_BYTES) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two");
   end

   logic [OFS_W-1:0]  ptr_q;
   logic [PAGE_BYTES-1:0] vld_vec;
   logic [DATA_W-1:0] slot_data [PAGE_BYTES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ptr_q <= '0;
      else if (load) ptr_q <= load_ofs;
      else if (push) ptr_q <= ptr_q + 1'b1;
   end

   for (genvar s = 0; s < PAGE_BYTES; s++) begin : g_slot
      logic [DATA_W-1:0] byte_q;
      logic              vld_q;
      logic              hit;
      assign hit = push && (ptr_q == OFS_W'(s));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   byte_q <= '0;
         else if (hit) byte_q <= push_data;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              vld_q <= 1'b0;
         else if (load || clear)  vld_q <= 1'b0;
         else if (hit)            vld_q <= 1'b1;
      end
      assign vld_vec[s]   = vld_q;
      assign slot_data[s] = byte_q;
   end

   assign rd_vld  = vld_vec[rd_idx];
   assign rd_data = slot_data[rd_idx];
   assign any_vld = |vld_vec;

   // Each accepted byte leaves its slot marked (R2, R3)
   assert_push_marks_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !load && !clear) |=> vld_vec[$past(ptr_q)]);
endmodule

// File: rtl/pwb_protect.sv
module pwb_protect #(
   parameter  int ADDR_W     = 9,
   parameter  int NUM_BLOCKS = 4,
   localparam int BLK_W      = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
   input  logic [ADDR_W-1:0]     addr,
   input  logic [NUM_BLOCKS-1:0] wp_flags,
   output logic                  hit
);
   if (NUM_BLOCKS > 1 && (1 << BLK_W) != NUM_BLOCKS) begin : g_bad_blocks
      $error("NUM_BLOCKS must be a power of two");
   end

   if (NUM_BLOCKS == 1) begin : g_single
      assign hit = wp_flags[0];
   end else begin : g_multi
      logic [BLK_W-1:0] blk;
      assign blk = addr[ADDR_W-1 -: BLK_W];
      assign hit = wp_flags[blk];
   end
endmodule

// File: rtl/pwb_busy_timer.sv
module pwb_busy_timer #(
   parameter  int CYCLES = 250000,
   localparam int CW     = $clog2(CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic last
);
   logic [CW-1:0] cnt_q;
   logic          busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (start && !busy_q) begin
         busy_q <= 1'b1;
         cnt_q  <= CW'(CYCLES - 1);
      end else if (busy_q) begin
         if (cnt_q == '0) busy_q <= 1'b0;
         else             cnt_q  <= cnt_q - 1'b1;
      end
   end

   assign busy = busy_q;
   assign last = busy_q && (cnt_q == '0);

   assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (cnt_q < CW'(CYCLES)));
   assert_start_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy_q) |=> busy_q);
endmodule

// File: rtl/pwb_page_writer.sv
module pwb_page_writer
   import pwb_pkg::*;
#(
   parameter int ADDR_W       = 9,
   parameter int DATA_W       = 8,
   parameter int PAGE_BYTES   = 16,
   parameter int NUM_BLOCKS   = 4,
   parameter int WRITE_CYCLES = 250000
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_open,
   input  logic [ADDR_W-1:0]     wr_addr,
   input  logic                  data_vld,
   input  logic [DATA_W-1:0]     data_byte,
   input  logic                  bus_stop,
   input  logic                  bus_abort,
   input  logic [NUM_BLOCKS-1:0] wp_block,
   output logic                  mem_we,
   output logic [ADDR_W-1:0]     mem_addr,
   output logic [DATA_W-1:0]     mem_wdata,
   output logic                  busy
);
   localparam int OFS_W = $clog2(PAGE_BYTES);
   localparam int PG_W  = ADDR_W - OFS_W;
   localparam logic [OFS_W-1:0] LAST_SLOT = OFS_W'(PAGE_BYTES - 1);

   if (WRITE_CYCLES < PAGE_BYTES + 2) begin : g_bad_cycles
      $error("WRITE_CYCLES must cover the page drain");
   end
   if (PG_W < 1) begin : g_bad_addr
      $error("ADDR_W must exceed the page offset width");
   end

   pwb_state_e       state_q;
   logic [PG_W-1:0]  page_q;
   logic [OFS_W-1:0] scan_q;
   logic             scan_run_q;
   logic             in_fill, do_open, do_abort, do_stop, do_commit, do_push, scan_end;
   logic             rd_vld, any_vld, prot_hit, tmr_busy, tmr_last;
   logic [DATA_W-1:0] rd_data;
   logic             mem_we_q;
   logic [ADDR_W-1:0] mem_addr_q;
   logic [DATA_W-1:0] mem_wdata_q;

   // Priority inside a transaction: abort, stop, reopen, byte
   always_comb begin
      in_fill   = (state_q == PWB_FILL);
      do_abort  = in_fill && bus_abort;
      do_stop   = in_fill && !bus_abort && bus_stop;
      do_open   = wr_open && ((state_q == PWB_IDLE) || (in_fill && !bus_abort && !bus_stop));
      do_push   = in_fill && !bus_abort && !bus_stop && !wr_open && data_vld;
      do_commit = do_stop && any_vld && !prot_hit;
      scan_end  = scan_run_q && (scan_q == LAST_SLOT);
   end

   pwb_page_store #(.DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (do_open),
      .load_ofs  (wr_addr[OFS_W-1:0]),
      .clear     (do_abort || (do_stop && !do_commit) || scan_end),
      .push      (do_push),
      .push_data (data_byte),
      .rd_idx    (scan_q),
      .rd_vld    (rd_vld),
      .rd_data   (rd_data),
      .any_vld   (any_vld)
   );

   pwb_protect #(.ADDR_W(ADDR_W), .NUM_BLOCKS(NUM_BLOCKS)) u_protect (
      .addr     ({page_q, {OFS_W{1'b0}}}),
      .wp_flags (wp_block),
      .hit      (prot_hit)
   );

   pwb_busy_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (do_commit),
      .busy  (tmr_busy),
      .last  (tmr_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PWB_IDLE;
         page_q  <= '0;
      end else begin
         if (do_open) page_q <= wr_addr[ADDR_W-1:OFS_W];
         case (state_q)
            PWB_IDLE:   if (do_open) state_q <= PWB_FILL;
            PWB_FILL: begin
               if (do_abort)     state_q <= PWB_IDLE;
               else if (do_stop) state_q <= do_commit ? PWB_COMMIT : PWB_IDLE;
            end
            PWB_COMMIT: if (tmr_last) state_q <= PWB_IDLE;
            default:    state_q <= PWB_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scan_q     <= '0;
         scan_run_q <= 1'b0;
      end else if (do_commit) begin
         scan_q     <= '0;
         scan_run_q <= 1'b1;
      end else if (scan_run_q) begin
         scan_q <= scan_q + 1'b1;
         if (scan_q == LAST_SLOT) scan_run_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_we_q    <= 1'b0;
         mem_addr_q  <= '0;
         mem_wdata_q <= '0;
      end else begin
         mem_we_q <= scan_run_q && rd_vld;
         if (scan_run_q && rd_vld) begin
            mem_addr_q  <= {page_q, scan_q};
            mem_wdata_q <= rd_data;
         end
      end
   end

   assign mem_we    = mem_we_q;
   assign mem_addr  = mem_addr_q;
   assign mem_wdata = mem_wdata_q;
   assign busy      = tmr_busy;

   assert_we_in_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> busy);
   assert_busy_after_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(bus_stop));
   assert_no_protected_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !$past(prot_hit));
   assert_abort_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
      do_abort |=> (!any_vld && !busy));
   assert_page_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !tmr_last) |=> $stable(page_q));
endmodule

// File: tb/pwb_page_writer_bench.sv
module pwb_page_writer_bench;
   localparam int AW = 9, DW = 8, PB = 16, NB = 4, WC = 40;

   logic clk = 1'b0, rst_n = 1'b0;
   logic wr_open = 0, data_vld = 0, bus_stop = 0, bus_abort = 0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] data_byte = '0;
   logic [NB-1:0] wp_block = '0;
   logic mem_we, busy;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;

   always #10 clk = ~clk;

   pwb_page_writer #(.ADDR_W(AW), .DATA_W(DW), .PAGE_BYTES(PB), .NUM_BLOCKS(NB),
                     .WRITE_CYCLES(WC)) u_pwb_page_writer (
      .clk(clk), .rst_n(rst_n), .wr_open(wr_open), .wr_addr(wr_addr),
      .data_vld(data_vld), .data_byte(data_byte), .bus_stop(bus_stop),
      .bus_abort(bus_abort), .wp_block(wp_block), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy));

   int n_chk = 0, n_fail = 0;
   int busy_cnt, wr_cnt, dup_cnt, stray_cnt;
   logic [DW-1:0] got_d [512];
   bit got_h [512];

   always @(negedge clk) if (rst_n) begin
      if (busy) busy_cnt++;
      if (mem_we) begin
         wr_cnt++;
         if (!busy) stray_cnt++;
         if (got_h[mem_addr]) dup_cnt++;
         got_h[mem_addr] = 1'b1;
         got_d[mem_addr] = mem_wdata;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic clr_mon();
      busy_cnt = 0; wr_cnt = 0; dup_cnt = 0; stray_cnt = 0;
      for (int i = 0; i < 512; i++) got_h[i] = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_byte(input logic [DW-1:0] d);
      data_vld = 1; data_byte = d; @(negedge clk); data_vld = 0;
   endtask

   // Expected slot contents are rebuilt from R2/R3: slot advances from wr_addr[3:0], last writer wins
   task automatic run_txn(input logic [AW-1:0] a, input int n, input logic [NB-1:0] wp,
                          input bit abort_end, input int gap_max, input bit disturb);
      logic [DW-1:0] eb [PB];
      bit ev [PB];
      int p, nv;
      bit commit;
      logic [DW-1:0] d;
      logic [AW-1:0] ea;
      string tag;
      clr_mon();
      wp_block = wp;
      for (int i = 0; i < PB; i++) begin ev[i] = 0; eb[i] = '0; end
      wr_addr = a; wr_open = 1; @(negedge clk); wr_open = 0; wr_addr = AW'($urandom);
      p = int'(a[3:0]);
      for (int k = 0; k < n; k++) begin
         d = DW'($urandom);
         send_byte(d);
         eb[p] = d; ev[p] = 1; p = (p + 1) % PB;
         idle($urandom_range(0, gap_max));
      end
      if (abort_end) bus_abort = 1; else bus_stop = 1;
      @(negedge clk); bus_abort = 0; bus_stop = 0;
      if (disturb) begin
         idle(3);
         wr_addr = a ^ 9'h100; wr_open = 1; @(negedge clk); wr_open = 0;
         send_byte(8'hA5); send_byte(8'h5A);
         bus_stop = 1; @(negedge clk); bus_stop = 0;
         idle(WC);
      end else idle(WC + 6);
      commit = !abort_end && (n > 0) && !wp[a[8:7]];
      nv = 0;
      for (int i = 0; i < PB; i++) nv += int'(ev[i]);
      chk(busy == 1'b0, "R6 busy low after cycle", int'(busy), 0);
      if (commit) begin
         chk(busy_cnt == WC, disturb ? "R8 busy length" : "R6 busy length", busy_cnt, WC);
         chk(wr_cnt == nv && dup_cnt == 0, disturb ? "R8 write count" : "R7 write count", wr_cnt, nv);
         chk(stray_cnt == 0, "R7 write outside busy", stray_cnt, 0);
         tag = (n > PB) ? "R3 slot data" : "R2 slot data";
         for (int i = 0; i < PB; i++) if (ev[i]) begin
            ea = {a[8:4], 4'(i)};
            chk(got_h[ea] && got_d[ea] == eb[i], tag, int'(got_d[ea]), int'(eb[i]));
         end
      end else begin
         tag = abort_end ? "R4 no write" : (n == 0 ? "R9 no write" : "R5 no write");
         chk(busy_cnt == 0, tag, busy_cnt, 0);
         chk(wr_cnt == 0, tag, wr_cnt, 0);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements): actual hung expected done");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed));
      idle(3);
      chk(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
      chk(mem_we == 1'b0, "R1 mem_we in reset", int'(mem_we), 0);
      rst_n = 1;
      idle(2);
      chk(busy == 1'b0 && mem_we == 1'b0, "R1 after reset", int'(busy), 0);

      // Directed corners
      run_txn(9'h040, 1, 4'h0, 0, 0, 0);   // R2 single byte
      run_txn(9'h1FE, 5, 4'h0, 0, 1, 0);   // R2 wrap within page, top page
      run_txn(9'h0A0, 16, 4'h0, 0, 0, 0);  // R2 full page
      run_txn(9'h0A7, 17, 4'h0, 0, 0, 0);  // R3 one over
      run_txn(9'h123, 40, 4'h0, 0, 2, 0);  // R3 deep overflow
      run_txn(9'h0F0, 6, 4'h0, 1, 0, 0);   // R4 abort
      run_txn(9'h1C0, 4, 4'h8, 0, 0, 0);   // R5 block 3 protected
      run_txn(9'h010, 4, 4'hE, 0, 0, 0);   // R5 other blocks protected, block 0 open
      run_txn(9'h030, 0, 4'h0, 0, 0, 0);   // R9 empty
      run_txn(9'h055, 9, 4'h0, 0, 0, 1);   // R8 disturbance while busy

      // R9: bytes and Stop with no open transaction
      clr_mon();
      send_byte(8'h11); send_byte(8'h22);
      bus_stop = 1; @(negedge clk); bus_stop = 0;
      idle(WC + 4);
      chk(busy_cnt == 0 && wr_cnt == 0, "R9 bytes outside transaction", wr_cnt, 0);

      // Random mix
      for (int t = 0; t < 60; t++) begin
         logic [NB-1:0] wp;
         wp = ($urandom_range(0, 1) == 0) ? '0 : NB'($urandom);
         run_txn(AW'($urandom), $urandom_range(0, 40), wp,
                 $urandom_range(0, 99) < 15, 2, 0);
      end

      summary();
      $finish;
   end
endmodule